// File: doc/BRIEF.md
# CAN Transmit Message Buffer Slot

This block holds a single outgoing CAN message and the commands that control it. Software reaches four 32-bit words through a word-addressed write strobe and a combinational read port: a control/command word, an identifier word and two payload words. Toward a transmit engine the block shows whether a request is pending, the frame format (remote flag, extended flag, raw length code), the usable byte count and the eight payload bytes in the order they go on the wire.

The engine reports three single-cycle events: arbitration won, arbitration lost and successful transmission. A success retires the request and, if enabled, produces a one-cycle interrupt pulse. An abort command is not acted on at once. It waits for the next arbitration loss, and a win cancels it. Guard bits in the written control word decide whether the format fields and the interrupt enable take the written values. Software can therefore re-issue the same message by writing only the command bits.

Word map (address index): 0 control/command, 1 identifier, 2 payload high, 3 payload low.

Top module: `can_txbuf_slot`

## Requirements
- R1: After reset every readable word reads 0, `tx_pending` is 0 and `tx_irq` is 0.
- R2: A control write changes the remote flag (bit 21), extended flag (bit 20) and length code (bits 19:16) only when written bit 23 is 1. Bit 23 always reads 0.
- R3: A control write changes the interrupt enable (bit 2) only when written bit 3 is 1. Bit 3 always reads 0.
- R4: Writing 1 to control bit 0 while nothing is pending makes the request pending: bit 0 reads 1 and `tx_pending` is 1. A success event clears it.
- R5: Writing 1 to control bit 1 while a request is pending sets the abort (bit 1). The abort holds until the next arbitration-loss event. That event clears both abort and request in the same cycle.
- R6: An arbitration-won event clears a pending abort and leaves the request pending.
- R7: A success event on a pending request raises `tx_irq` for exactly one cycle, in the cycle after the event, only when the interrupt enable is 1.
- R8: The identifier word holds the 29-bit identifier in bits 31:3 and drives it on `frm_id`. Bits 2:0 read 0.
- R9: `frm_dlc` carries the stored length code unchanged. `frm_nbytes` equals the code for codes 0 to 8 and equals 8 for codes 9 to 15.
- R10: `frm_payload[8k+7:8k]` is wire byte k+1. With `swap_bytes`=0, payload-high bits 31:24 hold byte 1 down to bits 7:0 holding byte 4, and payload-low holds bytes 5 to 8 in the same way. With `swap_bytes`=1 the byte order inside each word is reversed.
- R11: While a request is pending, writes to the identifier, the payload words and the format fields are ignored, and an abort write is still accepted.
- R12: A single control write that sets both bit 0 and bit 1 with nothing pending starts the request and does not set the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| swap_bytes | input | 1 | Reverses the byte order inside each payload word |
| evt_arb_won | input | 1 | Engine: this message won arbitration |
| evt_arb_lost | input | 1 | Engine: this message lost arbitration |
| evt_tx_ok | input | 1 | Engine: this message was sent successfully |
| tx_pending | output | 1 | Transmit request pending |
| frm_remote | output | 1 | Remote frame flag |
| frm_extended | output | 1 | Extended identifier flag |
| frm_dlc | output | 4 | Raw length code |
| frm_nbytes | output | 4 | Payload byte count, at most 8 |
| frm_id | output | 29 | Identifier |
| frm_payload | output | 64 | Payload bytes in wire order, byte 1 in bits 7:0 |
| tx_irq | output | 1 | One-cycle transmit-complete interrupt |

## Verification
The bench sweeps all sixteen length codes. A clamp placed at the wrong boundary would report 9 bytes or cut off byte 8. Every payload byte is checked in both byte orders, so a lane swapped across words or left unreversed shows up as a wrong byte. The deferred abort is exercised around arbitration events: an abort that takes effect at once would drop the request before any loss, and one that ignores a win would later remove a message that is already being sent. Writes with the guard bits clear, writes while a request is pending, and a combined request-plus-abort write all check that nothing changed that should have stayed. An interrupt that fires with the enable off or lasts two cycles is reported.

// File: rtl/can_txbuf_pkg.sv
// Shared word indices, field positions and the frame-format type of the
// transmit buffer slot. Assumes a 32-bit register word.
package can_txbuf_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int ID_W       = 29;
    localparam int DLC_W      = 4;
    localparam int NUM_BYTES  = 8;
    localparam int MAX_BYTES  = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_ID   = 2'd1;
    localparam logic [ADDR_W-1:0] A_DHI  = 2'd2;
    localparam logic [ADDR_W-1:0] A_DLO  = 2'd3;

    // control word bit positions
    localparam int B_REQ   = 0;
    localparam int B_ABT   = 1;
    localparam int B_IE    = 2;
    localparam int B_IEGD  = 3;
    localparam int B_DLC   = 16;
    localparam int B_EXT   = 20;
    localparam int B_RMT   = 21;
    localparam int B_FMTGD = 23;

    typedef struct packed {
        logic             remote;
        logic             extended;
        logic [DLC_W-1:0] dlc;
    } fmt_t;
endpackage

// File: rtl/can_txbuf_ctrl.sv
// Command and format state of the slot: request, deferred abort, interrupt
// enable and frame format. Assumes engine events are single-cycle pulses.
module can_txbuf_ctrl
    import can_txbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic w_req,
    input  logic w_abt,
    input  logic w_ie,
    input  logic w_ie_guard,
    input  logic w_fmt_guard,
    input  fmt_t w_fmt,
    input  logic evt_arb_won,
    input  logic evt_arb_lost,
    input  logic evt_tx_ok,
    output logic req_q,
    output logic abt_q,
    output logic ie_q,
    output fmt_t fmt_q,
    output logic irq_q
);
    logic req_n, abt_n;

    // Next request/abort: writes first, then engine events override them
    always_comb begin
        req_n = req_q;
        abt_n = abt_q;
        if (ctrl_wr && !req_q && w_req) req_n = 1'b1;
        if (ctrl_wr && req_q && w_abt)  abt_n = 1'b1;
        if (evt_arb_won)                abt_n = 1'b0;
        if (evt_arb_lost && abt_q) begin
            req_n = 1'b0;
            abt_n = 1'b0;
        end
        if (evt_tx_ok && req_q) begin
            req_n = 1'b0;
            abt_n = 1'b0;
        end
    end

    // Command state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            abt_q <= 1'b0;
        end else begin
            req_q <= req_n;
            abt_q <= abt_n;
        end
    end

    // Guarded control fields; format locked while a request is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            fmt_q <= '0;
        end else if (ctrl_wr) begin
            if (w_ie_guard)             ie_q  <= w_ie;
            if (w_fmt_guard && !req_q)  fmt_q <= w_fmt;
        end
    end

    // Transmit-complete interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= evt_tx_ok && req_q && ie_q;
    end

    a_r5_abort_implies_req: assert property (@(posedge clk) disable iff (!rst_n)
        abt_q |-> req_q);
    a_r5_lost_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_arb_lost && abt_q) |=> (!req_q && !abt_q));
    a_r6_won_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_arb_won && req_q && !evt_tx_ok && !(evt_arb_lost && abt_q)) |=> (req_q && !abt_q));
    a_r7_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !req_q);
    a_r11_fmt_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_q) |-> $stable(fmt_q));
endmodule

// File: rtl/can_txbuf_store.sv
// Identifier and payload storage. Writes are dropped while the slot is
// locked by a pending request. Assumes word-wide writes.
module can_txbuf_store
    import can_txbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              locked,
    output logic [ID_W-1:0]   id_q,
    output logic [REG_W-1:0]  dhi_q,
    output logic [REG_W-1:0]  dlo_q
);
    localparam int ID_LSB = REG_W - ID_W;

    // Message content registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            dhi_q <= '0;
            dlo_q <= '0;
        end else if (wr && !locked) begin
            case (addr)
                A_ID:    id_q  <= wdata[REG_W-1:ID_LSB];
                A_DHI:   dhi_q <= wdata;
                A_DLO:   dlo_q <= wdata;
                default: ;
            endcase
        end
    end

    a_r11_content_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> ($stable(id_q) && $stable(dhi_q) && $stable(dlo_q)));
endmodule

// File: rtl/can_txbuf_unpack.sv
// Presents the payload words as wire-ordered bytes and limits the byte
// count. Purely combinational; assumes two payload words of four bytes.
module can_txbuf_unpack
    import can_txbuf_pkg::*;
(
    input  logic [REG_W-1:0]          dhi,
    input  logic [REG_W-1:0]          dlo,
    input  logic                      swap,
    input  logic [DLC_W-1:0]          dlc,
    output logic [DLC_W-1:0]          nbytes,
    output logic [8*NUM_BYTES-1:0]    payload
);
    localparam int PER_WORD = REG_W / 8;

    // Byte k+1 from its word lane, reversed when swapped
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        localparam int POS = k % PER_WORD;
        logic [REG_W-1:0] word;
        assign word = (k < PER_WORD) ? dhi : dlo;
        assign payload[8*k +: 8] = swap ? word[8*POS +: 8]
                                        : word[8*(PER_WORD-1-POS) +: 8];
    end

    // Byte count clamp
    always_comb begin
        nbytes = (dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc;
    end

    always_comb begin
        a_r9_count_bound: assert (nbytes <= DLC_W'(MAX_BYTES));
    end
endmodule

// File: rtl/can_txbuf_slot.sv
// One CAN transmit message buffer: register port, command state, content
// storage and wire-order presentation to a transmit engine.
// Assumes the register port and the engine share the clock.
module can_txbuf_slot
    import can_txbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              swap_bytes,
    input  logic              evt_arb_won,
    input  logic              evt_arb_lost,
    input  logic              evt_tx_ok,
    output logic              tx_pending,
    output logic              frm_remote,
    output logic              frm_extended,
    output logic [3:0]        frm_dlc,
    output logic [3:0]        frm_nbytes,
    output logic [28:0]       frm_id,
    output logic [63:0]       frm_payload,
    output logic              tx_irq
);
    logic ctrl_wr, req_q, abt_q, ie_q;
    fmt_t w_fmt, fmt_q;
    logic [REG_W-1:0] dhi_q, dlo_q;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign w_fmt   = '{remote:   reg_wdata[B_RMT],
                       extended: reg_wdata[B_EXT],
                       dlc:      reg_wdata[B_DLC +: DLC_W]};

    can_txbuf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .w_req(reg_wdata[B_REQ]), .w_abt(reg_wdata[B_ABT]),
        .w_ie(reg_wdata[B_IE]), .w_ie_guard(reg_wdata[B_IEGD]),
        .w_fmt_guard(reg_wdata[B_FMTGD]), .w_fmt(w_fmt),
        .evt_arb_won(evt_arb_won), .evt_arb_lost(evt_arb_lost),
        .evt_tx_ok(evt_tx_ok), .req_q(req_q), .abt_q(abt_q),
        .ie_q(ie_q), .fmt_q(fmt_q), .irq_q(tx_irq)
    );

    can_txbuf_store u_store (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .locked(req_q), .id_q(frm_id),
        .dhi_q(dhi_q), .dlo_q(dlo_q)
    );

    can_txbuf_unpack u_unpack (
        .dhi(dhi_q), .dlo(dlo_q), .swap(swap_bytes), .dlc(fmt_q.dlc),
        .nbytes(frm_nbytes), .payload(frm_payload)
    );

    assign tx_pending   = req_q;
    assign frm_remote   = fmt_q.remote;
    assign frm_extended = fmt_q.extended;
    assign frm_dlc      = fmt_q.dlc;

    // Read-back mux; guard bits and reserved bits read 0
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_REQ]            = req_q;
                reg_rdata[B_ABT]            = abt_q;
                reg_rdata[B_IE]             = ie_q;
                reg_rdata[B_DLC +: DLC_W]   = fmt_q.dlc;
                reg_rdata[B_EXT]            = fmt_q.extended;
                reg_rdata[B_RMT]            = fmt_q.remote;
            end
            A_ID:    reg_rdata = {frm_id, {(REG_W-ID_W){1'b0}}};
            A_DHI:   reg_rdata = dhi_q;
            default: reg_rdata = dlo_q;
        endcase
    end

    a_r4_pending_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> (reg_rdata[B_REQ] == tx_pending));
    a_r12_no_abort_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !tx_pending && reg_wdata[B_ABT]) |=> !abt_q);
endmodule

// File: tb/can_txbuf_slot_bench.sv
module can_txbuf_slot_bench;
    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic swap_bytes = 0, evt_arb_won = 0, evt_arb_lost = 0, evt_tx_ok = 0;
    logic tx_pending, frm_remote, frm_extended, tx_irq;
    logic [3:0] frm_dlc, frm_nbytes;
    logic [28:0] frm_id;
    logic [63:0] frm_payload;
    int total = 0, bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    can_txbuf_slot u_can_txbuf_slot (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #0.5; d = reg_rdata;
    endtask

    task automatic pulse(input int which);
        evt_arb_won = (which == 0); evt_arb_lost = (which == 1); evt_tx_ok = (which == 2);
        tick();
        evt_arb_won = 0; evt_arb_lost = 0; evt_tx_ok = 0;
    endtask

    initial begin
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        @(negedge clk); tick(); tick(); rst_n = 1; tick();
        // R1 reset state
        for (int a = 0; a < 4; a++) begin rd(2'(a), r); chk("R1 word", r, 0); end
        chk("R1 pending", tx_pending, 0);
        chk("R1 irq", tx_irq, 0);

        // R9 sweep of all length codes
        for (int d = 0; d < 16; d++) begin
            wr(0, (32'd1 << 23) | (32'(d) << 16));
            chk("R9 dlc", frm_dlc, d);
            chk("R9 nbytes", frm_nbytes, (d > 8) ? 8 : d);
        end

        // R2 format guard
        wr(0, (32'd1 << 23) | (32'd1 << 21) | (32'd5 << 16));
        rd(0, r); chk("R2 fmt set", r, (32'd1 << 21) | (32'd5 << 16));
        wr(0, (32'd1 << 20) | (32'd2 << 16));
        rd(0, r); chk("R2 guard off keeps", r, (32'd1 << 21) | (32'd5 << 16));
        wr(0, (32'd1 << 23) | (32'd1 << 20) | (32'd3 << 16));
        chk("R2 ext", {frm_remote, frm_extended, frm_dlc}, {2'b01, 4'd3});

        // R3 interrupt enable guard
        wr(0, 32'h4);
        rd(0, r); chk("R3 guard off", r[3:2], 2'b00);
        wr(0, 32'hC);
        rd(0, r); chk("R3 guard on", r[3:2], 2'b01);

        // R8 identifier
        wr(1, 32'hFFFF_FFFF);
        rd(1, r); chk("R8 id read", r, 32'hFFFF_FFF8);
        chk("R8 id out", frm_id, 29'h1FFF_FFFF);
        wr(1, 32'h1234_5677);
        chk("R8 id out2", frm_id, 29'(32'h1234_5677 >> 3));

        // R10 byte order, several patterns, both settings
        for (int p = 0; p < 4; p++) begin
            logic [31:0] hi, lo;
            hi = 32'h0102_0304 * (p + 1) ^ (32'hA5 << (8 * p));
            lo = 32'h1122_3344 + 32'h0F0F_0F0F * p;
            wr(2, hi); wr(3, lo);
            for (int s = 0; s < 2; s++) begin
                swap_bytes = s[0]; #0.5;
                for (int k = 0; k < 8; k++) begin
                    logic [31:0] w; int lane;
                    w = (k < 4) ? hi : lo;
                    lane = s ? (k % 4) : (3 - k % 4);
                    chk("R10 byte", frm_payload[8*k +: 8], (w >> (8 * lane)) & 32'hFF);
                end
            end
        end
        swap_bytes = 0;

        // R4 request and success; R7 irq with enable on
        wr(0, 32'h1);
        chk("R4 pending", tx_pending, 1);
        rd(0, r); chk("R4 read bit0", r[0], 1);
        // R11 writes ignored while pending
        rd(1, r); begin
            logic [31:0] idv; idv = r;
            wr(1, 32'hDEAD_BEEF); rd(1, r); chk("R11 id locked", r, idv);
        end
        rd(2, r); begin
            logic [31:0] hv; hv = r;
            wr(2, 32'h5555_AAAA); rd(2, r); chk("R11 data locked", r, hv);
        end
        wr(0, (32'd1 << 23) | (32'd7 << 16) | 32'h1);
        chk("R11 fmt locked", frm_dlc, 3);
        pulse(2);
        chk("R7 irq", tx_irq, 1);
        chk("R4 cleared", tx_pending, 0);
        tick();
        chk("R7 irq one cycle", tx_irq, 0);

        // R5 deferred abort, R11 abort accepted while pending
        wr(0, 32'h1);
        wr(0, 32'h2);
        rd(0, r); chk("R5 abort set", r[1:0], 2'b11);
        tick(); tick();
        rd(0, r); chk("R5 abort waits", r[1:0], 2'b11);
        pulse(1);
        rd(0, r); chk("R5 lost withdraws", r[1:0], 2'b00);
        chk("R5 irq none", tx_irq, 0);

        // R6 win cancels abort
        wr(0, 32'h1); wr(0, 32'h2);
        pulse(0);
        rd(0, r); chk("R6 won", r[1:0], 2'b01);
        pulse(1);
        chk("R6 lost after win keeps", tx_pending, 1);

        // R7 no irq with enable off
        wr(0, 32'h8);
        pulse(2);
        chk("R7 no irq ie off", tx_irq, 0);
        chk("R4 success clears", tx_pending, 0);

        // R12 combined request and abort
        wr(0, 32'h3);
        rd(0, r); chk("R12 abort ignored", r[1:0], 2'b01);
        pulse(1);
        chk("R12 still pending", tx_pending, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule